// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block performs the configuration step of a vector unit. Each request carries a requested element count (the application vector length) and a proposed type word. The unit first decides whether the type word is legal and writes the type register. From the newly written type it derives the largest element count the register file can hold for that element width and register grouping. It then grants a vector length from the request and that maximum, and returns the granted length as the destination-register result. In the same cycle it emits a strobe that tells the start-index register to clear.

Both the requested length and the type word can come either from a full-width register operand or from a small immediate that is zero-extended. Requested lengths between one and two times the maximum are handled by a fixed build-time policy: either half the request rounded up, or the maximum. All results are registered and appear one clock after the request strobe.

Top module: `vcfg_unit`

## Requirements
- R1: After synchronous reset, `vtype_q` holds only bit XLEN-1 set (the illegal flag) and every other bit at 0. `vl_q`, `rd_data`, `done` and `vstart_clr` are 0.
- R2: A proposed type word with bit XLEN-1 set is illegal.
- R3: A proposed type word with bit 5 set is illegal. Bit 5 is the top bit of the element-width field in bits 5:3, so codes 4 to 7 are reserved.
- R4: Grouping code 3'b100 in bits 2:0 is illegal. With XLEN=32, code 3'b101 is also illegal.
- R5: An illegal word stores `vtype_q = 1 << (XLEN-1)`. A legal word stores its bits 7:0 unchanged with all higher bits 0. The field layout is: grouping in bits 2:0, element width in bits 5:3, tail policy in bit 6, mask policy in bit 7.
- R6: The maximum count is VLEN / (8 << width code) multiplied by the grouping factor. Grouping codes 0 to 3 give factors 1, 2, 4 and 8; codes 5, 6 and 7 give 1/8, 1/4 and 1/2, with integer truncation. The maximum is computed from the newly written type, and it is 0 when that type is illegal.
- R7: If the request is below the maximum, the granted length is the request. If the request is at least twice the maximum, the granted length is the maximum.
- R8: If the request lies in [max, 2·max), the grant is (request+1)/2 when HALF_TO_MAX=0, and the maximum when HALF_TO_MAX=1.
- R9: One clock after `cfg_valid`, `vl_q` and `rd_data` both hold the granted length, and `done` and `vstart_clr` are both 1 for exactly that cycle.
- R10: `use_imm_avl` selects the zero-extended `avl_imm` over `avl_reg`. `use_imm_vtype` selects the zero-extended `vtype_imm` over `vtype_req`.
- R11: In a cycle without `cfg_valid`, `vtype_q`, `vl_q` and `rd_data` keep their values, and `done` and `vstart_clr` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | One-cycle request strobe |
| use_imm_avl | input | 1 | Take the requested length from the immediate |
| avl_reg | input | XLEN | Requested length, register form |
| avl_imm | input | AVL_IMM_W | Requested length, immediate form |
| use_imm_vtype | input | 1 | Take the type word from the immediate |
| vtype_req | input | XLEN | Proposed type word, register form |
| vtype_imm | input | VTYPE_IMM_W | Proposed type word, immediate form |
| vtype_q | output | XLEN | Type register |
| vl_q | output | XLEN | Granted length register |
| rd_data | output | XLEN | Destination-register result |
| done | output | 1 | Result valid, one cycle |
| vstart_clr | output | 1 | Clear strobe for the start-index register |

## Verification
The bench sweeps all 256 low type bytes. For each one it drives requests just below, at and just above the maximum and twice the maximum, plus zero and the all-ones request. Two instances cover both band policies. A unit that derived the maximum from the old type, or that misordered the fractional grouping divisors, would grant wrong lengths at these exact boundaries. A unit that kept field bits from an illegal word, or let bits above 7 leak into the stored type, would show a wrong `vtype_q`. Immediate forms with upper bits set and an idle-hold phase catch bad source selection and spurious updates.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int unsigned VT_FIELD_W = 8;
  localparam logic [2:0] LMUL_CODE_RSVD = 3'b100;
  localparam logic [2:0] LMUL_CODE_EIGHTH = 3'b101;

  typedef struct packed {
    logic       mask_agn;
    logic       tail_agn;
    logic [2:0] width_code;
    logic [2:0] group_code;
  } vtype_fields_t;
endpackage

// File: rtl/vcfg_type_check.sv
module vcfg_type_check
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] type_word,
  output logic            type_ok,
  output vtype_fields_t   fields
);
  logic frac_rsvd;

  generate
    if (XLEN == 32) begin : g_narrow
      assign frac_rsvd = (type_word[2:0] == LMUL_CODE_EIGHTH);
    end else begin : g_wide
      assign frac_rsvd = 1'b0;
    end
  endgenerate

  always_comb begin
    type_ok = !(type_word[XLEN-1] || type_word[5] ||
                (type_word[2:0] == LMUL_CODE_RSVD) || frac_rsvd);
    fields  = type_ok ? vtype_fields_t'(type_word[VT_FIELD_W-1:0]) : '0;
  end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLEN = 128
) (
  input  logic            type_ok,
  input  vtype_fields_t   fields,
  output logic [XLEN-1:0] vlmax
);
  localparam int unsigned SW = $clog2(VLEN) + 4;

  logic [SW-1:0] scaled;
  logic [1:0]    up_sh;
  logic [3:0]    dn_sh;

  always_comb begin
    up_sh  = fields.group_code[2] ? 2'd0 : fields.group_code[1:0];
    dn_sh  = 4'd3 + {1'b0, fields.width_code} +
             (fields.group_code[2] ? (4'd8 - {1'b0, fields.group_code}) : 4'd0);
    scaled = (SW'(VLEN) << up_sh) >> dn_sh;
    vlmax  = type_ok ? XLEN'(scaled) : '0;
  end
endmodule

// File: rtl/vcfg_len_grant.sv
module vcfg_len_grant #(
  parameter int unsigned XLEN        = 32,
  parameter bit          HALF_TO_MAX = 1'b0
) (
  input  logic [XLEN-1:0] avl,
  input  logic [XLEN-1:0] vlmax,
  output logic [XLEN-1:0] vl
);
  localparam int unsigned XW = XLEN + 1;

  logic [XW-1:0]   avl_w, max_w, dbl_w, half_w;
  logic [XLEN-1:0] band_vl;

  always_comb begin
    avl_w  = {1'b0, avl};
    max_w  = {1'b0, vlmax};
    dbl_w  = max_w << 1;
    half_w = (avl_w + XW'(1)) >> 1;
  end

  generate
    if (HALF_TO_MAX) begin : g_band_max
      assign band_vl = vlmax;
    end else begin : g_band_half
      assign band_vl = half_w[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    if (avl_w < max_w)      vl = avl;
    else if (avl_w < dbl_w) vl = band_vl;
    else                    vl = vlmax;
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned VLEN        = 128,
  parameter int unsigned AVL_IMM_W   = 5,
  parameter int unsigned VTYPE_IMM_W = 10,
  parameter bit          HALF_TO_MAX = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_valid,
  input  logic                   use_imm_avl,
  input  logic [XLEN-1:0]        avl_reg,
  input  logic [AVL_IMM_W-1:0]   avl_imm,
  input  logic                   use_imm_vtype,
  input  logic [XLEN-1:0]        vtype_req,
  input  logic [VTYPE_IMM_W-1:0] vtype_imm,
  output logic [XLEN-1:0]        vtype_q,
  output logic [XLEN-1:0]        vl_q,
  output logic [XLEN-1:0]        rd_data,
  output logic                   done,
  output logic                   vstart_clr
);
  localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] avl_sel, type_sel, vlmax, vl_next, vtype_next;
  logic            type_ok;
  vtype_fields_t   fields;

  always_comb begin
    avl_sel  = use_imm_avl   ? XLEN'(avl_imm)   : avl_reg;
    type_sel = use_imm_vtype ? XLEN'(vtype_imm) : vtype_req;
  end

  vcfg_type_check #(.XLEN(XLEN)) type_chk_i (
    .type_word(type_sel),
    .type_ok  (type_ok),
    .fields   (fields)
  );

  vcfg_vlmax #(.XLEN(XLEN), .VLEN(VLEN)) vlmax_i (
    .type_ok(type_ok),
    .fields (fields),
    .vlmax  (vlmax)
  );

  vcfg_len_grant #(.XLEN(XLEN), .HALF_TO_MAX(HALF_TO_MAX)) grant_i (
    .avl  (avl_sel),
    .vlmax(vlmax),
    .vl   (vl_next)
  );

  always_comb begin
    vtype_next = '0;
    if (type_ok) vtype_next[VT_FIELD_W-1:0] = fields;
    else         vtype_next = ILL_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vtype_q    <= ILL_WORD;
      vl_q       <= '0;
      rd_data    <= '0;
      done       <= 1'b0;
      vstart_clr <= 1'b0;
    end else begin
      done       <= cfg_valid;
      vstart_clr <= cfg_valid;
      if (cfg_valid) begin
        vtype_q <= vtype_next;
        vl_q    <= vl_next;
        rd_data <= vl_next;
      end
    end
  end
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_valid,
  input logic [XLEN-1:0] vtype_q,
  input logic [XLEN-1:0] vl_q,
  input logic [XLEN-1:0] rd_data,
  input logic            done,
  input logic            vstart_clr
);
  p_ill_clears_fields_r5: assert property (@(posedge clk) disable iff (rst)
    vtype_q[XLEN-1] |-> (vtype_q[XLEN-2:0] == '0));

  p_ill_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
    vtype_q[XLEN-1] |-> (vl_q == '0));

  p_no_rsvd_group_r4: assert property (@(posedge clk) disable iff (rst)
    !vtype_q[XLEN-1] |-> (vtype_q[2:0] != 3'b100));

  p_no_rsvd_width_r3: assert property (@(posedge clk) disable iff (rst)
    !vtype_q[XLEN-1] |-> !vtype_q[5]);

  p_result_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> (done && vstart_clr && (rd_data == vl_q)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |=> (!done && !vstart_clr && $stable(vl_q) && $stable(vtype_q)
                    && $stable(rd_data)));
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg_valid (cfg_valid),
  .vtype_q   (vtype_q),
  .vl_q      (vl_q),
  .rd_data   (rd_data),
  .done      (done),
  .vstart_clr(vstart_clr)
);

// File: tb/vcfg_unit_tb_top.sv
`timescale 1ns/1ps
module vcfg_unit_tb_top;
  localparam int unsigned XLEN = 32;
  localparam int unsigned VLEN = 128;
  localparam int unsigned AIW  = 5;
  localparam int unsigned VIW  = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_valid = 1'b0;
  logic            use_imm_avl = 1'b0;
  logic [XLEN-1:0] avl_reg = '0;
  logic [AIW-1:0]  avl_imm = '0;
  logic            use_imm_vtype = 1'b0;
  logic [XLEN-1:0] vtype_req = '0;
  logic [VIW-1:0]  vtype_imm = '0;

  logic [XLEN-1:0] vt_h, vl_h, rd_h, vt_m, vl_m, rd_m;
  logic            dn_h, vc_h, dn_m, vc_m;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .AVL_IMM_W(AIW), .VTYPE_IMM_W(VIW),
              .HALF_TO_MAX(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .use_imm_avl(use_imm_avl),
    .avl_reg(avl_reg), .avl_imm(avl_imm), .use_imm_vtype(use_imm_vtype),
    .vtype_req(vtype_req), .vtype_imm(vtype_imm), .vtype_q(vt_h), .vl_q(vl_h),
    .rd_data(rd_h), .done(dn_h), .vstart_clr(vc_h));

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .AVL_IMM_W(AIW), .VTYPE_IMM_W(VIW),
              .HALF_TO_MAX(1'b1)) dut_max_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .use_imm_avl(use_imm_avl),
    .avl_reg(avl_reg), .avl_imm(avl_imm), .use_imm_vtype(use_imm_vtype),
    .vtype_req(vtype_req), .vtype_imm(vtype_imm), .vtype_q(vt_m), .vl_q(vl_m),
    .rd_data(rd_m), .done(dn_m), .vstart_clr(vc_m));

  task automatic chk(input string rq, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic bit legal_word(input longint w);
    longint g = w & 7;
    return !(((w >> 31) & 1) != 0 || ((w >> 5) & 1) != 0 || g == 4 || g == 5);
  endfunction

  function automatic longint exp_max(input longint w);
    longint sew, num, den;
    if (!legal_word(w)) return 0;
    sew = 8 << ((w >> 3) & 7);
    if ((w & 7) < 4) begin num = 1 << (w & 7); den = 1; end
    else begin num = 1; den = 1 << (8 - (w & 7)); end
    return (VLEN * num) / (sew * den);
  endfunction

  function automatic longint exp_len(input longint avl, input longint mx, input bit to_max);
    if (avl < mx) return avl;
    if (avl < 2 * mx) return to_max ? mx : (avl + 1) / 2;
    return mx;
  endfunction

  task automatic run_op(input bit ia, input longint areg, input longint aimm,
                        input bit iv, input longint vreg, input longint vimm,
                        input string rq);
    longint avl = ia ? aimm : areg;
    longint w   = iv ? vimm : vreg;
    longint mx  = exp_max(w);
    longint evt = legal_word(w) ? (w & 'hFF) : (64'd1 << 31);
    @(negedge clk);
    use_imm_avl = ia; avl_reg = XLEN'(areg); avl_imm = AIW'(aimm);
    use_imm_vtype = iv; vtype_req = XLEN'(vreg); vtype_imm = VIW'(vimm);
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk({rq, " R5 vtype"}, vt_h, evt);
    chk({rq, " R5 vtype max-policy"}, vt_m, evt);
    chk({rq, " R8 vl half-policy"}, vl_h, exp_len(avl, mx, 1'b0));
    chk({rq, " R8 vl max-policy"}, vl_m, exp_len(avl, mx, 1'b1));
    chk({rq, " R9 rd"}, rd_h, exp_len(avl, mx, 1'b0));
    chk({rq, " R9 done/vstart"}, {dn_h, vc_h, dn_m, vc_m}, 4'hF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    longint av[9];
    longint keep_vl, keep_vt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 vtype", vt_h, 64'd1 << 31);
    chk("R1 vl", vl_h, 0);
    chk("R1 rd", rd_h, 0);
    chk("R1 strobes", {dn_h, vc_h, dn_m, vc_m}, 0);

    // R6 R7 R8 sweep over every low type byte
    for (int vt = 0; vt < 256; vt++) begin
      longint mx = exp_max(vt);
      av[0] = 0; av[1] = (mx > 0) ? mx - 1 : 1; av[2] = mx; av[3] = mx + 1;
      av[4] = (mx > 0) ? 2 * mx - 1 : 2; av[5] = 2 * mx; av[6] = 2 * mx + 1;
      av[7] = 'hFFFF_FFFF; av[8] = 1;
      for (int k = 0; k < 9; k++)
        run_op(1'b0, av[k], 0, 1'b0, vt, 0, "R6 R7 sweep");
    end

    // R2 top bit illegal, R3 width, R4 grouping codes
    run_op(1'b0, 40, 0, 1'b0, 'h8000_0008, 0, "R2 top bit");
    run_op(1'b0, 40, 0, 1'b0, 'h0000_0020, 0, "R3 width 4");
    run_op(1'b0, 40, 0, 1'b0, 'h0000_0004, 0, "R4 group 100");
    run_op(1'b0, 40, 0, 1'b0, 'h0000_0005, 0, "R4 group 101");
    // R5 bits above 7 dropped on a legal word
    run_op(1'b0, 7, 0, 1'b0, 'h7FFF_FFC1, 0, "R5 upper bits");

    // R10 immediate forms; register operands hold conflicting values
    for (int a = 0; a < 32; a++)
      run_op(1'b1, 'hFFFF_FFFF, a, 1'b1, 'h8000_0000, 'h300 | (a & 'hC3), "R10 imm");
    run_op(1'b0, 9, 31, 1'b1, 'h20, 'h0D1, "R10 reg avl imm type");
    run_op(1'b1, 3, 17, 1'b0, 'h42, 'h3FF, "R10 imm avl reg type");

    // R11 idle hold with changing inputs
    keep_vl = vl_h; keep_vt = vt_h;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      avl_reg = XLEN'(i * 13); vtype_req = XLEN'(i);
      use_imm_avl = i[0]; use_imm_vtype = i[1];
      @(negedge clk);
      chk("R11 vl held", vl_h, keep_vl);
      chk("R11 vtype held", vt_h, keep_vt);
      chk("R11 strobes low", {dn_h, vc_h}, 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule